// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Pin-Change Detection

This block collects every interrupt source of a small 8-bit controller core and turns them into one CPU interrupt request and one wake-from-sleep request. The core-level sources are a timer rollover, an external edge request, a shared pin-change event and a group of eleven peripheral requests. Each peripheral request first meets its own enable. The OR of the enabled peripherals then meets a group enable. The core sources and the group result are ORed, and that combined level is the wake request. Only after that does the global enable gate it into the CPU request, so the core can be woken while global interrupts are off.

Ten input pins are watched for level changes. Bits 0-5 of the pin vector are port A pins 0-5, and bits 6-9 are port B pins 4-7. Each pin passes through a two-flop synchroniser. Each pin that is enabled for change detection is then compared with a snapshot, and software refreshes that snapshot by reading the port. All flags are sticky and are cleared through a small register write port.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every flag, every enable, the snapshot, `irq_o` and `wake_o` are 0.
- R2: Core register bit 2 (timer flag) is set on the clock edge where the sampled timer count moves from all-ones (FFh) to 0, and on no other transition.
- R3: A high `ext_req_i` at a clock edge sets core register bit 1 (external flag).
- R4: Core register bit 0 (pin-change flag) is set one edge after a synchronised pin differs from its snapshot, but only for a pin whose bit is 1 in the pin-enable register (address 3). A pin whose enable is 0 never sets the flag.
- R5: A high `port_rd_i` at an edge copies the synchronised pins into the snapshot. A mismatch present at that same edge is lost and does not set the flag.
- R6: `pin_val_o` shows each pin input after exactly two clock edges.
- R7: Peripheral flag i (address 1, bit i) is set by `periph_req_i[i]`. It contributes to the requests only when enable bit i (address 2) and core bit 6 (group enable) are both 1.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A set event at the same edge as a clearing write leaves the flag set. Core bits 3, 4 and 5 are the enables for the pin-change, external and timer flags.
- R9: `irq_o` is registered. It is 1 one edge after the combined enabled request and core bit 7 (global enable) are both 1.
- R10: `wake_o` is registered from the combined enabled request, with no dependence on the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt_i | input | 8 | Current timer count |
| ext_req_i | input | 1 | External edge request pulse |
| periph_req_i | input | 11 | Peripheral request pulses |
| pins_i | input | 10 | Watched pins (A0-A5, B4-B7) |
| port_rd_i | input | 1 | Port read strobe; refreshes the snapshot |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 core, 1 peripheral flags, 2 peripheral enables, 3 pin enables |
| wr_data_i | input | 16 | Write data |
| core_reg_o | output | 8 | Core flags and enables |
| periph_flag_o | output | 11 | Peripheral flags |
| pin_val_o | output | 10 | Synchronised pin values |
| irq_o | output | 1 | CPU interrupt request |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
A wrong flag bit appears on `core_reg_o` or `periph_flag_o` on the edge after the event. A stale or corrupted snapshot shows up as a missing or spurious pin-change flag about three edges after a pin moves. A bad enable or gating term is visible at `irq_o` or `wake_o` one edge later. The bench therefore compares both the flags and the two request outputs one cycle apart for every source and every enable setting.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    ADDR_CORE  = 2'd0,
    ADDR_PFLAG = 2'd1,
    ADDR_PEN   = 2'd2,
    ADDR_PINEN = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_PCHG_F = 0;
  localparam int unsigned BIT_EXT_F  = 1;
  localparam int unsigned BIT_TMR_F  = 2;
  localparam int unsigned BIT_PCHG_E = 3;
  localparam int unsigned BIT_EXT_E  = 4;
  localparam int unsigned BIT_TMR_E  = 5;
  localparam int unsigned BIT_GRP_E  = 6;
  localparam int unsigned BIT_GLB_E  = 7;
  localparam int unsigned CORE_W     = 8;
  localparam int unsigned N_CORE_F   = 3;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] pin_en_i,
  input  logic         port_rd_i,
  output logic         chg_evt_o
);
  logic [W-1:0] snap_q, snap_d;
  logic         mismatch;

  always_comb begin
    snap_d = snap_q;
    if (port_rd_i) snap_d = pin_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // A read at the same edge as a mismatch overwrites it: the change is lost.
  assign mismatch  = |((pin_s_i ^ snap_q) & pin_en_i);
  assign chg_evt_o = mismatch & ~port_rd_i;
endmodule

// File: rtl/irq_periph_bank.sv
module irq_periph_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         wr_flag_i,
  input  logic         wr_en_reg_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flag_o,
  output logic         grp_req_o
);
  logic [N-1:0] flag_q, flag_d, en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en_reg_i) en_d = wr_data_i;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_comb begin
        flag_d[i] = req_i[i] | (flag_q[i] & ~(wr_flag_i & ~wr_data_i[i]));
      end

      a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !(wr_flag_i && !wr_data_i[i])) |=> flag_q[i]);
      a_r7_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[i] |=> flag_q[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flag_o    = flag_q;
  assign grp_req_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned NUM_PINS   = 10,
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TMR_W-1:0]      tmr_cnt_i,
  input  logic                  ext_req_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  port_rd_i,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [CORE_W-1:0]     core_reg_o,
  output logic [NUM_PERIPH-1:0] periph_flag_o,
  output logic [NUM_PINS-1:0]   pin_val_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic wr_core, wr_pflag, wr_pen, wr_pinen;
  assign wr_core  = wr_en_i && (wr_addr_i == ADDR_CORE);
  assign wr_pflag = wr_en_i && (wr_addr_i == ADDR_PFLAG);
  assign wr_pen   = wr_en_i && (wr_addr_i == ADDR_PEN);
  assign wr_pinen = wr_en_i && (wr_addr_i == ADDR_PINEN);

  // timer rollover detection
  logic [TMR_W-1:0] cnt_q;
  logic             ovf_evt;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= tmr_cnt_i;
  end
  assign ovf_evt = (&cnt_q) && (tmr_cnt_i == '0);

  // pins: synchroniser and change detection
  logic [NUM_PINS-1:0] pin_s, pin_en_q, pin_en_d;
  logic                chg_evt;

  irq_sync2 #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .d_i   (pins_i),
    .q_o   (pin_s)
  );

  always_comb begin
    pin_en_d = pin_en_q;
    if (wr_pinen) pin_en_d = wr_data_i[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pin_en_q <= '0;
    else         pin_en_q <= pin_en_d;
  end

  irq_change_det #(.W(NUM_PINS)) u_chg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .pin_s_i   (pin_s),
    .pin_en_i  (pin_en_q),
    .port_rd_i (port_rd_i),
    .chg_evt_o (chg_evt)
  );

  // peripheral group
  logic grp_req;
  irq_periph_bank #(.N(NUM_PERIPH)) u_periph (
    .clk         (clk),
    .rst_n       (rst_ns),
    .req_i       (periph_req_i),
    .wr_flag_i   (wr_pflag),
    .wr_en_reg_i (wr_pen),
    .wr_data_i   (wr_data_i[NUM_PERIPH-1:0]),
    .flag_o      (periph_flag_o),
    .grp_req_o   (grp_req)
  );

  // core register
  logic [CORE_W-1:0]   core_q, core_d;
  logic [N_CORE_F-1:0] set_evt;
  assign set_evt[BIT_PCHG_F] = chg_evt;
  assign set_evt[BIT_EXT_F]  = ext_req_i;
  assign set_evt[BIT_TMR_F]  = ovf_evt;

  always_comb begin
    core_d = core_q;
    if (wr_core) begin
      core_d[CORE_W-1:N_CORE_F] = wr_data_i[CORE_W-1:N_CORE_F];
      core_d[N_CORE_F-1:0]      = core_q[N_CORE_F-1:0] & wr_data_i[N_CORE_F-1:0];
    end
    core_d[N_CORE_F-1:0] = core_d[N_CORE_F-1:0] | set_evt;
  end

  logic core_any, irq_d, wake_d;
  assign core_any = (core_q[BIT_TMR_F]  & core_q[BIT_TMR_E])
                  | (core_q[BIT_EXT_F]  & core_q[BIT_EXT_E])
                  | (core_q[BIT_PCHG_F] & core_q[BIT_PCHG_E])
                  | (grp_req            & core_q[BIT_GRP_E]);
  assign wake_d = core_any;
  assign irq_d  = core_any & core_q[BIT_GLB_E];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      core_q <= '0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      core_q <= core_d;
      irq_o  <= irq_d;
      wake_o <= wake_d;
    end
  end

  assign core_reg_o = core_q;
  assign pin_val_o  = pin_s;

  a_r2_tmr_rollover: assert property (@(posedge clk) disable iff (!rst_ns)
    ((&cnt_q) && (tmr_cnt_i == '0)) |=> core_q[BIT_TMR_F]);
  a_r3_ext_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    ext_req_i |=> core_q[BIT_EXT_F]);
  a_r4_change_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    chg_evt |=> core_q[BIT_PCHG_F]);
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_ns)
    (core_any && core_q[BIT_GLB_E]) |=> irq_o);
  a_r10_wake_without_global: assert property (@(posedge clk) disable iff (!rst_ns)
    (core_any && !core_q[BIT_GLB_E]) |=> (wake_o && !irq_o));
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam int NP = 11;
  localparam int NPIN = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      tmr_cnt;
  logic            ext_req;
  logic [NP-1:0]   periph_req;
  logic [NPIN-1:0] pins;
  logic            port_rd;
  logic            wr_en;
  logic [1:0]      wr_addr;
  logic [15:0]     wr_data;
  logic [7:0]      core_reg;
  logic [NP-1:0]   pflag;
  logic [NPIN-1:0] pin_val;
  logic            irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .tmr_cnt_i(tmr_cnt), .ext_req_i(ext_req),
    .periph_req_i(periph_req), .pins_i(pins), .port_rd_i(port_rd),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .core_reg_o(core_reg), .periph_flag_o(pflag), .pin_val_o(pin_val),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tmr_cnt = 8'h55; ext_req = 1'b0; periph_req = '0;
    pins = '0; port_rd = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check(core_reg, 0, "R1 core");
    check(pflag, 0, "R1 pflag");
    check(irq, 0, "R1 irq");
    check(wake, 0, "R1 wake");

    // R6 synchroniser latency, pins disabled so no flag (R4)
    pins = 10'h3FF;
    tick();
    check(pin_val, 0, "R6 one edge");
    tick();
    check(pin_val, 10'h3FF, "R6 two edges");
    tick(2);
    check(core_reg[0], 0, "R4 disabled pins");
    pins = '0;
    tick(3);

    // R4 sweep over pins and enable polarity
    wr(2'd0, 16'h0008);
    for (int p = 0; p < NPIN; p++) begin
      for (int en = 0; en < 2; en++) begin
        wr(2'd3, en ? (16'h1 << p) : (~(16'h1 << p) & 16'h3FF));
        pins[p] = ~pins[p];
        tick(3);
        check(core_reg[0], en, "R4 pin change flag");
        tick();
        check(irq, 0, "R9 no global");
        check(wake, en, "R10 wake");
        port_rd = 1'b1; tick(); port_rd = 1'b0;
        wr(2'd0, 16'h0008);
        check(core_reg[0], 0, "R8 clear pin flag");
        tick();
      end
    end

    // R5 change coincident with a port read is lost
    wr(2'd3, 16'h3FF);
    pins[3] = ~pins[3];
    tick(2);
    port_rd = 1'b1; tick(); port_rd = 1'b0;
    tick(3);
    check(core_reg[0], 0, "R5 coincident read");
    pins[5] = ~pins[5];
    tick(3);
    check(core_reg[0], 1, "R5 later change seen");
    port_rd = 1'b1; tick(); port_rd = 1'b0;
    wr(2'd3, 16'h0);
    wr(2'd0, 16'h0020);

    // R2 timer transition sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] pv, cv;
        pv = (a == 0) ? 8'h00 : (a == 1) ? 8'h7F : (a == 2) ? 8'hFE : 8'hFF;
        cv = (b == 0) ? 8'h00 : (b == 1) ? 8'h01 : (b == 2) ? 8'h80 : 8'hFF;
        tmr_cnt = 8'h55; tick();
        tmr_cnt = pv; tick();
        tmr_cnt = cv; tick();
        check(core_reg[2], (pv == 8'hFF && cv == 8'h00) ? 1 : 0, "R2 rollover");
        wr(2'd0, 16'h0020);
        check(core_reg[2], 0, "R8 clear timer");
      end
    end
    tmr_cnt = 8'h55; tick(2);

    // R3, R9, R10, R8 on the external source
    wr(2'd0, 16'h0090);
    tick();
    ext_req = 1'b1; tick(); ext_req = 1'b0;
    check(core_reg[1], 1, "R3 ext flag");
    check(irq, 0, "R9 registered delay");
    tick();
    check(irq, 1, "R9 irq");
    check(wake, 1, "R10 wake with global");
    wr(2'd0, 16'h0012);
    tick();
    check(irq, 0, "R9 global off");
    check(wake, 1, "R10 wake global off");
    check(core_reg[1], 1, "R8 write one keeps");
    ext_req = 1'b1;
    wr(2'd0, 16'h0010);
    ext_req = 1'b0;
    check(core_reg[1], 1, "R8 set beats clear");
    wr(2'd0, 16'h0010);
    check(core_reg[1], 0, "R8 clear ext");
    tick();

    // R7 peripheral sweep
    wr(2'd0, 16'h00C0);
    for (int i = 0; i < NP; i++) begin
      for (int en = 0; en < 2; en++) begin
        wr(2'd2, en ? (16'h1 << i) : (~(16'h1 << i) & 16'h7FF));
        periph_req[i] = 1'b1; tick(); periph_req[i] = 1'b0;
        check(pflag, 1 << i, "R7 flag set");
        tick();
        check(irq, en, "R7 irq gating");
        check(wake, en, "R7 wake gating");
        wr(2'd1, 16'h0);
        check(pflag, 0, "R8 clear periph");
        tick();
      end
    end

    // R7 group enable off blocks everything
    wr(2'd0, 16'h0080);
    wr(2'd2, 16'h7FF);
    periph_req = 11'h7FF; tick(); periph_req = '0;
    tick();
    check(pflag, 11'h7FF, "R7 flags with group off");
    check(irq, 0, "R7 group off irq");
    check(wake, 0, "R7 group off wake");
    wr(2'd1, 16'h7FF);
    check(pflag, 11'h7FF, "R8 write ones keeps");
    wr(2'd1, 16'h0);
    periph_req[4] = 1'b1;
    wr(2'd1, 16'h0);
    periph_req[4] = 1'b0;
    check(pflag, 11'h010, "R8 periph set beats clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule